// File: doc/BRIEF.md
# Dual-Edge Triggered Digital One-Shot

A synchronous monostable pulse generator that replaces a resistor-capacitor timed one-shot with a cycle counter. Two trigger inputs are provided. One fires on a high-to-low change and the other fires on a low-to-high change. When a trigger is accepted, the output goes high for a programmed number of clock cycles and then returns to its stable state. A complementary output is always driven alongside it.

Both trigger inputs are asynchronous to the clock. Each passes through a two-flop synchronizer and an edge detector before it reaches the timer. The pulse is not retriggerable: edges that arrive while a pulse is running are dropped. An active-low synchronous clear forces the stable state and blocks triggers while it is held low. A dual device is built by placing two instances side by side.

Top module: `dual_edge_oneshot`

## Requirements
- R1: A high-to-low change on `trig_fall_i` starts a pulse. If the input changes between clock edges, `q_o` is first high after the third rising clock edge that follows (two synchronizer stages, then the detect-to-set register).
- R2: A low-to-high change on `trig_rise_i` starts a pulse with the same latency as R1.
- R3: While `clear_ni` is sampled low at a clock edge, `q_o` is low and the cycle counter is zero after that edge. A running pulse is therefore cut off one clock after `clear_ni` goes low.
- R4: A trigger edge that is detected while `clear_ni` is low is discarded. It does not produce a pulse after the clear is released.
- R5: Once a pulse has started, edges on either trigger input are ignored until the pulse has ended. The pulse length is unchanged by them.
- R6: `q_o` stays high for exactly `width_i` clock cycles. The value used is the one present at the clock edge that accepts the trigger; later changes to `width_i` do not affect the running pulse. The counter holds zero in the stable state.
- R7: A `width_i` of 0 gives a pulse of exactly one cycle.
- R8: `q_no` is the complement of `q_o` at all times.
- R9: Edges on both trigger inputs that are detected in the same cycle produce a single pulse.
- R10: After `rst_ni` is released, `q_o` is low. A trigger input that is held at its post-edge level through reset does not fire a pulse.
- R11: A trigger that arrives after a pulse has ended starts a new pulse. This holds for a trigger arriving in the cycle right after the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_ni | input | 1 | Synchronous clear, active low; forces the stable state and blocks triggers |
| trig_fall_i | input | 1 | Trigger input, fires on a high-to-low change (asynchronous) |
| trig_rise_i | input | 1 | Trigger input, fires on a low-to-high change (asynchronous) |
| width_i | input | WIDTH_W | Pulse length in clock cycles; 0 acts as 1 |
| q_o | output | 1 | Pulse output, high while timing |
| q_no | output | 1 | Complement of q_o |

## Verification
The in-line properties check the following on every cycle:
- Clear forces the idle state on the next edge.
- A pulse only begins from an edge sampled while clear was high.
- A running pulse holds with its latched length until the counter reaches that length.
- The pulse falls exactly at that point.
- Each edge detector emits single-cycle strobes.

Several behaviours need the scoreboard scenarios, which compare rise cycle and length per pulse:
- the end-to-end trigger latency through the synchronizers;
- the loss of edges seen during clear or during a pulse;
- the merging of coincident edges;
- the suppression of a level held through reset.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/os_edge_sync.sv
module os_edge_sync
  import oneshot_pkg::*;
#(
  parameter edge_pol_e POL    = EDGE_RISE,
  parameter int        STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  // reset value chosen so a level held through reset is never seen as an edge
  localparam logic IdleVal = (POL == EDGE_RISE);
  localparam int   SyncIdx = STAGES - 1;

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES + 1){IdleVal}};
    else         sh_q <= {sh_q[STAGES-1:0], lvl_i};
  end

  generate
    if (POL == EDGE_RISE) begin : g_rise
      assign edge_o = sh_q[SyncIdx] & ~sh_q[STAGES];
    end else begin : g_fall
      assign edge_o = ~sh_q[SyncIdx] & sh_q[STAGES];
    end
  endgenerate

  // R1 / R2: a level change yields a single-cycle strobe
  assert_edge_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_ni,
  input  logic               fire_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o
);
  localparam logic [WIDTH_W-1:0] MinLen = WIDTH_W'(1);

  logic [WIDTH_W-1:0] cnt_q, lim_q;
  logic               q_q;
  logic               done;

  assign done = (cnt_q >= lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
      lim_q <= MinLen;
    end else if (!clear_ni) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (!q_q) begin
      if (fire_i) begin
        q_q   <= 1'b1;
        cnt_q <= MinLen;
        lim_q <= (width_i == '0) ? MinLen : width_i;
      end
    end else if (done) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + MinLen;
    end
  end

  assign q_o = q_q;

  assert_clear_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |=> (!q_q && cnt_q == '0));

  assert_accept_clear_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |-> $past(clear_ni));

  assert_no_retrigger_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q && !done && clear_ni) |=> (q_q && $stable(lim_q)));

  assert_pulse_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_q && done) |=> !q_q);

  assert_idle_count_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_q |-> (cnt_q == '0));

  assert_limit_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |-> (lim_q != '0 && cnt_q == MinLen));
endmodule

// File: rtl/dual_edge_oneshot.sv
module dual_edge_oneshot
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_ni,
  input  logic               trig_fall_i,
  input  logic               trig_rise_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               q_no
);
  logic fall_edge, rise_edge, fire;

  os_edge_sync #(.POL(EDGE_FALL), .STAGES(SYNC_STAGES)) u_sync_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (trig_fall_i),
    .edge_o(fall_edge)
  );

  os_edge_sync #(.POL(EDGE_RISE), .STAGES(SYNC_STAGES)) u_sync_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (trig_rise_i),
    .edge_o(rise_edge)
  );

  // coincident edges merge into one request (R9)
  assign fire = fall_edge | rise_edge;

  os_pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_ni(clear_ni),
    .fire_i  (fire),
    .width_i (width_i),
    .q_o     (q_o)
  );

  assign q_no = ~q_o;

  assert_rise_needs_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(fall_edge || rise_edge));
endmodule

// File: tb/dual_edge_oneshot_tb_top.sv
`timescale 1ns/1ps
module dual_edge_oneshot_tb_top;
  localparam int WW = 8;

  typedef struct {
    int    start;
    int    len;
    string req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clear_ni = 1'b1;
  logic          trig_fall_i = 1'b1;
  logic          trig_rise_i = 1'b1;
  logic [WW-1:0] width_i = 8'd4;
  logic          q_o, q_no;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  int   comp_err = 0;
  int   rise_cyc = 0;
  logic q_prev = 1'b0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #4 clk_i = ~clk_i;   // 125 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  dual_edge_oneshot #(.WIDTH_W(WW)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_ni   (clear_ni),
    .trig_fall_i(trig_fall_i),
    .trig_rise_i(trig_rise_i),
    .width_i    (width_i),
    .q_o        (q_o),
    .q_no       (q_no)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int start, int len, string req);
    exp_t e;
    e.start = start; e.len = len; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pulse rise/fall observed away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (q_no !== ~q_o) comp_err++;
      if (q_o && !q_prev) rise_cyc = cyc;
      if (!q_o && q_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected pulse at cycle", rise_cyc, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rise_cyc == e.start, e.req, "pulse start", rise_cyc, e.start);
          chk(cyc - rise_cyc == e.len, e.req, "pulse length", cyc - rise_cyc, e.len);
        end
      end
      q_prev = q_o;
    end
  end

  task automatic fire_fall(int w, string req);
    @(negedge clk_i);
    width_i = WW'(w);
    trig_fall_i = 1'b0;
    push(cyc + 3, (w == 0) ? 1 : w, req);
    repeat (w + 8) @(negedge clk_i);
    trig_fall_i = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic fire_rise(int w, string req);
    @(negedge clk_i);
    width_i = WW'(w);
    trig_rise_i = 1'b1;
    push(cyc + 3, (w == 0) ? 1 : w, req);
    repeat (w + 8) @(negedge clk_i);
    trig_rise_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    // R10: trig_rise_i held high through reset must not fire
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk(q_o == 1'b0, "R10", "q_o after reset", int'(q_o), 0);
    chk(q_no == 1'b1, "R10", "q_no after reset", int'(q_no), 1);
    trig_rise_i = 1'b0;   // falling on rise input: no trigger
    repeat (6) @(negedge clk_i);

    fire_fall(5, "R1");
    fire_rise(3, "R2");
    fire_fall(0, "R7");
    fire_fall(1, "R6");

    // R6: width change after acceptance has no effect
    @(negedge clk_i);
    width_i = 8'd6;
    trig_rise_i = 1'b1;
    push(cyc + 3, 6, "R6");
    repeat (4) @(negedge clk_i);
    width_i = 8'd2;
    repeat (12) @(negedge clk_i);
    trig_rise_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R5: edges on both inputs during a pulse are ignored
    @(negedge clk_i);
    width_i = 8'd8;
    trig_fall_i = 1'b0;
    push(cyc + 3, 8, "R5");
    repeat (5) @(negedge clk_i);
    trig_fall_i = 1'b1;
    @(negedge clk_i);
    trig_fall_i = 1'b0;
    trig_rise_i = 1'b1;
    repeat (14) @(negedge clk_i);
    trig_fall_i = 1'b1;
    trig_rise_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R9: coincident edges make one pulse
    @(negedge clk_i);
    width_i = 8'd4;
    trig_fall_i = 1'b0;
    trig_rise_i = 1'b1;
    push(cyc + 3, 4, "R9");
    repeat (14) @(negedge clk_i);
    trig_fall_i = 1'b1;
    trig_rise_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R3: clear cuts a running pulse one clock later
    @(negedge clk_i);
    width_i = 8'd10;
    trig_fall_i = 1'b0;
    push(cyc + 3, 5, "R3");
    repeat (7) @(negedge clk_i);
    clear_ni = 1'b0;
    @(negedge clk_i);
    chk(q_o == 1'b0, "R3", "q_o during clear", int'(q_o), 0);
    // R4: edge during clear is discarded
    @(negedge clk_i);
    trig_rise_i = 1'b1;
    repeat (8) @(negedge clk_i);
    clear_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk(q_o == 1'b0, "R4", "q_o after clear release", int'(q_o), 0);
    trig_fall_i = 1'b1;
    trig_rise_i = 1'b0;
    repeat (6) @(negedge clk_i);

    // R11: back-to-back pulses
    @(negedge clk_i);
    width_i = 8'd2;
    trig_rise_i = 1'b1;
    push(cyc + 3, 2, "R11");
    repeat (5) @(negedge clk_i);
    width_i = 8'd3;
    trig_fall_i = 1'b0;
    push(cyc + 3, 3, "R11");
    repeat (12) @(negedge clk_i);
    trig_fall_i = 1'b1;
    trig_rise_i = 1'b0;
    repeat (6) @(negedge clk_i);

    chk(comp_err == 0, "R8", "q_no complement mismatches", comp_err, 0);
    chk(exp_q.size() == 0, "R1", "pulses missing", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired at cycle", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule